// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block keeps the in-flight stores of one thread in a circular buffer. A store takes a slot at the tail when it is dispatched, tagged with its sequence number. When it executes, its address, size and data are written into that slot. A commit request marks every store older than a given sequence number as committed. A committed store that has also executed may write back. A writeback pointer walks the buffer in age order and offers one store per cycle to memory, unless the store path reports that it is blocked. A slot is released at the head only after memory reports that its write has finished. A squash request trims uncommitted stores younger than a given sequence number from the tail.

Loads probe the buffer every cycle. The probe looks for the youngest executed, not yet completed store that is older than the load and shares at least one byte with it. If that store covers every byte of the load, its data is returned, aligned to the load address. If it covers only some of the bytes, a stall is raised: the load must wait for that store to write back, and then be replayed by the surrounding logic.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: store count 0, pending-writeback count 0, full low, no write offered, no forward hit or stall, allocation index 0.
- R2: The queue has DEPTH slots with one kept free. Full is high while the store count is DEPTH-1 or more, and an allocation request while full changes nothing. An accepted allocation takes the slot at the allocation index and clears all of that slot's flags.
- R3: A slot is freed at the head one clock edge after its write completion is recorded. The head never moves past a slot whose write has not completed. A completion report for a slot whose write was never issued is ignored.
- R4: A commit request marks every occupied store with sequence number strictly below the commit sequence as committed. A store may write back once it is both committed and executed, in either order.
- R5: The write request is high exactly when the slot at the writeback pointer is occupied, may write back, has not yet been issued, and the blocked input is low. The request carries that slot's index, address, size code and data, and the pointer then advances by one slot.
- R6: While the blocked input is high no write is offered and the writeback pointer holds, so the same store is offered again once the input falls.
- R7: The pending-writeback output counts the occupied slots that may write back and have not yet been issued.
- R8: The size code gives 1, 2, 4 or 8 bytes for codes 0 to 3. Store data is right-justified, so bits 7:0 hold the byte at the store address. The probe takes the youngest store that is older than the load, has executed, has not completed, and overlaps the load's bytes. If that store contains all of the load's bytes, hit is high and the data is the store data shifted right by eight times the address difference, then masked to the load size. Otherwise the data is zero.
- R9: If the chosen store overlaps the load only in part, stall is high and hit is low. Stores whose sequence number is not below the load's are not considered.
- R10: A squash removes every occupied uncommitted store whose sequence number is above the squash sequence. The tail and the count drop by the number removed, and an allocation in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocEn | input | 1 | Allocate a slot for a new store |
| allocSeq | input | SEQ_W | Sequence number of the new store |
| allocIdx | output | $clog2(DEPTH) | Slot the next allocation takes |
| sqFull | output | 1 | No allocation is accepted |
| execEn | input | 1 | A store has executed |
| execIdx | input | $clog2(DEPTH) | Slot of the executed store |
| execAddr | input | ADDR_W | Byte address of the store |
| execSize | input | 2 | Size code of the store |
| execData | input | 64 | Store data, right-justified |
| commitEn | input | 1 | Commit request |
| commitSeq | input | SEQ_W | Stores below this sequence commit |
| squashEn | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Uncommitted stores above this sequence are removed |
| wrBlocked | input | 1 | Store path cannot take a write |
| wrValid | output | 1 | Write offered to memory this cycle |
| wrIdx | output | $clog2(DEPTH) | Slot of the offered write |
| wrAddr | output | ADDR_W | Address of the offered write |
| wrSize | output | 2 | Size code of the offered write |
| wrData | output | 64 | Data of the offered write |
| wrDoneEn | input | 1 | A write has completed |
| wrDoneIdx | input | $clog2(DEPTH) | Slot whose write completed |
| ldSeq | input | SEQ_W | Sequence number of the probing load |
| ldAddr | input | ADDR_W | Byte address of the probing load |
| ldSize | input | 2 | Size code of the probing load |
| fwdHit | output | 1 | A store fully supplies the load |
| fwdStall | output | 1 | A store partly overlaps the load |
| fwdData | output | 64 | Forwarded data, right-justified |
| storeCount | output | $clog2(DEPTH)+1 | Occupied slots |
| pendingWb | output | $clog2(DEPTH)+1 | Stores ready and waiting to write back |

## Verification
The write request, its payload, the forward results and the full flag depend on the current state and the current inputs through logic alone. They are due in the same cycle the inputs are driven. Every change of state recorded at an edge (allocation, execution, commit, squash, issue, completion and release of the head) shows up on the outputs one edge later. Because of this, a completion takes two edges to lower the store count: one to record it and one to release the slot. The bench drives inputs just after the falling edge, compares all outputs a little later against a model that still holds the state before the next rising edge, and then advances the model by exactly one edge.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W = DATA_BYTES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } sizeCode_e;

  // control to datapath strobes
  typedef struct packed {
    logic fill;      // write address/size/data of the executing store
  } sqStrobe_t;

  function automatic logic [3:0] sizeBytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic [DATA_W-1:0] byteMask(input logic [1:0] code);
    logic [DATA_W-1:0] m;
    if (code == SZ_DBL) m = '1;
    else m = (DATA_W'(1) << (8 * int'(sizeBytes(code)))) - DATA_W'(1);
    return m;
  endfunction
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocEn,
  input  logic [SEQ_W-1:0] allocSeq,
  input  logic             execEn,
  input  logic [IDX_W-1:0] execIdx,
  input  logic             commitEn,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             squashEn,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             wrBlocked,
  input  logic             wrDoneEn,
  input  logic [IDX_W-1:0] wrDoneIdx,
  input  logic [SEQ_W-1:0] ldSeq,
  output logic [IDX_W-1:0] allocIdx,
  output logic             sqFull,
  output logic [CNT_W-1:0] storeCount,
  output logic [CNT_W-1:0] pendingWb,
  output logic             wrValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic [DEPTH-1:0] candMask,
  output sqStrobe_t        strobe
);
  logic [IDX_W-1:0] headQ, tailQ, wbQ;
  logic [CNT_W-1:0] cntQ;
  logic [SEQ_W-1:0] seqQ [DEPTH];
  logic [DEPTH-1:0] execQ, commQ, canWbQ, sentQ, doneQ;

  logic [DEPTH-1:0] occ, execHit, commHit, commNext, execNext, rmHit, doneHit;
  logic [CNT_W-1:0] rmCnt, pendCnt;
  logic             freeOk, allocOk;

  // occupancy from the age of each slot relative to the head
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [IDX_W-1:0] age;
    assign age        = IDX_W'(i) - headQ;
    assign occ[i]     = {1'b0, age} < cntQ;
    assign execHit[i] = execEn && occ[i] && (execIdx == IDX_W'(i));
    assign commHit[i] = commitEn && occ[i] && (seqQ[i] < commitSeq);
    assign commNext[i] = commQ[i] | commHit[i];
    assign execNext[i] = execQ[i] | execHit[i];
    assign rmHit[i]   = squashEn && occ[i] && (seqQ[i] > squashSeq) && !commNext[i];
    assign doneHit[i] = wrDoneEn && occ[i] && (wrDoneIdx == IDX_W'(i)) && sentQ[i] && !doneQ[i];
    assign candMask[i] = occ[i] && execQ[i] && !doneQ[i] && (seqQ[i] < ldSeq);
  end

  always_comb begin
    rmCnt   = '0;
    pendCnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rmCnt   = rmCnt + CNT_W'(rmHit[i]);
      pendCnt = pendCnt + CNT_W'(occ[i] && canWbQ[i] && !sentQ[i]);
    end
  end

  assign sqFull     = cntQ >= CNT_W'(DEPTH - 1);
  assign allocOk    = allocEn && !squashEn && !sqFull;
  assign freeOk     = (cntQ != '0) && doneQ[headQ];
  assign wrValid    = occ[wbQ] && canWbQ[wbQ] && !sentQ[wbQ] && !wrBlocked;
  assign strobe.fill = execEn && occ[execIdx];

  assign allocIdx   = tailQ;
  assign storeCount = cntQ;
  assign pendingWb  = pendCnt;
  assign wbIdx      = wbQ;
  assign headIdx    = headQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      wbQ    <= '0;
      cntQ   <= '0;
      execQ  <= '0;
      commQ  <= '0;
      canWbQ <= '0;
      sentQ  <= '0;
      doneQ  <= '0;
      for (int i = 0; i < DEPTH; i++) seqQ[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (allocOk && tailQ == IDX_W'(i)) begin
          seqQ[i]   <= allocSeq;
          execQ[i]  <= 1'b0;
          commQ[i]  <= 1'b0;
          canWbQ[i] <= 1'b0;
          sentQ[i]  <= 1'b0;
          doneQ[i]  <= 1'b0;
        end else begin
          execQ[i]  <= execNext[i];
          commQ[i]  <= commNext[i];
          canWbQ[i] <= canWbQ[i] | (commNext[i] & execNext[i]);
          sentQ[i]  <= sentQ[i] | (wrValid && wbQ == IDX_W'(i));
          doneQ[i]  <= doneQ[i] | doneHit[i];
        end
      end
      headQ <= headQ + IDX_W'(freeOk);
      wbQ   <= wbQ + IDX_W'(wrValid);
      tailQ <= tailQ - rmCnt[IDX_W-1:0] + IDX_W'(allocOk);
      cntQ  <= cntQ - CNT_W'(freeOk) - rmCnt + CNT_W'(allocOk);
    end
  end

  // occupancy never reaches the sentinel slot
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(DEPTH - 1));

  // a request while full never grows the queue
  assert_full_no_grow_R2: assert property (@(posedge clk) disable iff (!rstN)
    sqFull |=> cntQ <= $past(cntQ));

  // head holds while its write is still outstanding
  assert_head_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0 && !doneQ[headQ]) |=> headQ == $past(headQ));

  // a write is never offered into a blocked store path
  assert_no_issue_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !wrBlocked);

  // blocked path freezes the writeback pointer
  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrBlocked |=> wbQ == $past(wbQ));

  // a squash cycle never adds a store
  assert_squash_no_grow_R10: assert property (@(posedge clk) disable iff (!rstN)
    squashEn |=> cntQ <= $past(cntQ));
endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         strobe,
  input  logic [IDX_W-1:0]  execIdx,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic [1:0]        execSize,
  input  logic [DATA_W-1:0] execData,
  input  logic [IDX_W-1:0]  wbIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [DEPTH-1:0]  candMask,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [1:0]        wrSize,
  output logic [DATA_W-1:0] wrData,
  output logic              fwdHit,
  output logic              fwdStall,
  output logic [DATA_W-1:0] fwdData
);
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [1:0]        sizeQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        addrQ[i] <= '0;
        sizeQ[i] <= '0;
        dataQ[i] <= '0;
      end
    end else if (strobe.fill) begin
      addrQ[execIdx] <= execAddr;
      sizeQ[execIdx] <= execSize;
      dataQ[execIdx] <= execData;
    end
  end

  assign wrAddr = addrQ[wbIdx];
  assign wrSize = sizeQ[wbIdx];
  assign wrData = dataQ[wbIdx];

  // forwarding search: walk oldest to youngest, last overlap wins
  logic [ADDR_W:0]  ldStart, ldEnd, stStart, stEnd;
  logic [IDX_W-1:0] scanIdx, selIdx;
  logic             found, contain;
  logic [2:0]       shiftB;

  assign ldStart = {1'b0, ldAddr};
  assign ldEnd   = ldStart + (ADDR_W+1)'(sizeBytes(ldSize));

  always_comb begin
    found   = 1'b0;
    contain = 1'b0;
    selIdx  = '0;
    scanIdx = '0;
    stStart = '0;
    stEnd   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanIdx = headIdx + IDX_W'(k);
      if (candMask[scanIdx]) begin
        stStart = {1'b0, addrQ[scanIdx]};
        stEnd   = stStart + (ADDR_W+1)'(sizeBytes(sizeQ[scanIdx]));
        if (ldStart < stEnd && stStart < ldEnd) begin
          found   = 1'b1;
          selIdx  = scanIdx;
          contain = (ldStart >= stStart) && (ldEnd <= stEnd);
        end
      end
    end
  end

  assign shiftB   = ldAddr[2:0] - addrQ[selIdx][2:0];
  assign fwdHit   = found && contain;
  assign fwdStall = found && !contain;
  assign fwdData  = fwdHit ? ((dataQ[selIdx] >> {shiftB, 3'b000}) & byteMask(ldSize)) : '0;

  // a probe is either served or stalled, never both
  assert_fwd_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdHit && fwdStall));

  // no candidate store means no forwarding outcome
  assert_fwd_needs_cand_R8: assert property (@(posedge clk) disable iff (!rstN)
    (candMask == '0) |-> !(fwdHit || fwdStall));
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocEn,
  input  logic [SEQ_W-1:0]  allocSeq,
  output logic [IDX_W-1:0]  allocIdx,
  output logic              sqFull,
  input  logic              execEn,
  input  logic [IDX_W-1:0]  execIdx,
  input  logic [ADDR_W-1:0] execAddr,
  input  logic [1:0]        execSize,
  input  logic [63:0]       execData,
  input  logic              commitEn,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashEn,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              wrBlocked,
  output logic              wrValid,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [1:0]        wrSize,
  output logic [63:0]       wrData,
  input  logic              wrDoneEn,
  input  logic [IDX_W-1:0]  wrDoneIdx,
  input  logic [SEQ_W-1:0]  ldSeq,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  output logic              fwdHit,
  output logic              fwdStall,
  output logic [63:0]       fwdData,
  output logic [CNT_W-1:0]  storeCount,
  output logic [CNT_W-1:0]  pendingWb
);
  sqStrobe_t        strobe;
  logic [IDX_W-1:0] wbIdx, headIdx;
  logic [DEPTH-1:0] candMask;

  sq_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .allocEn(allocEn), .allocSeq(allocSeq),
    .execEn(execEn), .execIdx(execIdx),
    .commitEn(commitEn), .commitSeq(commitSeq),
    .squashEn(squashEn), .squashSeq(squashSeq),
    .wrBlocked(wrBlocked), .wrDoneEn(wrDoneEn), .wrDoneIdx(wrDoneIdx),
    .ldSeq(ldSeq),
    .allocIdx(allocIdx), .sqFull(sqFull),
    .storeCount(storeCount), .pendingWb(pendingWb),
    .wrValid(wrValid), .wbIdx(wbIdx), .headIdx(headIdx),
    .candMask(candMask), .strobe(strobe)
  );

  sq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .execIdx(execIdx), .execAddr(execAddr), .execSize(execSize), .execData(execData),
    .wbIdx(wbIdx), .headIdx(headIdx), .candMask(candMask),
    .ldAddr(ldAddr), .ldSize(ldSize),
    .wrAddr(wrAddr), .wrSize(wrSize), .wrData(wrData),
    .fwdHit(fwdHit), .fwdStall(fwdStall), .fwdData(fwdData)
  );

  assign wrIdx = wbIdx;
endmodule

// File: tb/test_store_queue.sv
module test_store_queue;
  localparam int D = 8;
  localparam int SW = 16;
  localparam int AW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic allocEn = 0, execEn = 0, commitEn = 0, squashEn = 0, wrBlocked = 0, wrDoneEn = 0;
  logic [SW-1:0] allocSeq = '0, commitSeq = '0, squashSeq = '0, ldSeq = '0;
  logic [2:0] execIdx = '0, wrDoneIdx = '0, allocIdx, wrIdx;
  logic [AW-1:0] execAddr = '0, ldAddr = '0, wrAddr;
  logic [1:0] execSize = '0, ldSize = '0, wrSize;
  logic [63:0] execData = '0, wrData, fwdData;
  logic sqFull, wrValid, fwdHit, fwdStall;
  logic [3:0] storeCount, pendingWb;

  store_queue i_store_queue (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int mSeq[D]; logic [31:0] mAddr[D]; logic [1:0] mSize[D]; logic [63:0] mData[D];
  bit mEx[D], mCm[D], mSt[D], mDn[D];
  int mHead = 0, mTail = 0, mWb = 0, mCnt = 0, nextSeq = 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit occ(int i);
    return ((i - mHead + D) % D) < mCnt;
  endfunction

  // compare all outputs against the model, then advance the model one edge
  task automatic cycle();
    bit expWr, found, cont, freeOk;
    int pend, sel, rm;
    longint ss, se, ls, le;
    logic [63:0] expFwd, mask;
    bit cmN[D];
    #1;
    chk("R2 full", sqFull, mCnt >= D-1);
    chk("R2 allocIdx", allocIdx, mTail);
    chk("R3 R10 count", storeCount, mCnt);
    pend = 0;
    for (int i = 0; i < D; i++) if (occ(i) && mCm[i] && mEx[i] && !mSt[i]) pend++;
    chk("R4 R7 pending", pendingWb, pend);
    expWr = occ(mWb) && mCm[mWb] && mEx[mWb] && !mSt[mWb] && !wrBlocked;
    chk("R5 R6 wrValid", wrValid, expWr);
    if (expWr) begin
      chk("R5 wrIdx", wrIdx, mWb);
      chk("R5 wrAddr", wrAddr, mAddr[mWb]);
      chk("R5 wrSize", wrSize, mSize[mWb]);
      chk("R5 wrData", wrData, mData[mWb]);
    end
    found = 0; cont = 0; sel = 0;
    ls = ldAddr; le = ls + (1 << ldSize);
    for (int k = 0; k < mCnt; k++) begin
      int s = (mHead + k) % D;
      if (mEx[s] && !mDn[s] && mSeq[s] < ldSeq) begin
        ss = mAddr[s]; se = ss + (1 << mSize[s]);
        if (ls < se && ss < le) begin found = 1; sel = s; cont = (ls >= ss) && (le <= se); end
      end
    end
    mask = (ldSize == 3) ? '1 : ((64'd1 << (8 * (1 << ldSize))) - 1);
    expFwd = (found && cont) ? ((mData[sel] >> (8 * (ls - longint'(mAddr[sel])))) & mask) : '0;
    chk("R8 fwdHit", fwdHit, found && cont);
    chk("R9 fwdStall", fwdStall, found && !cont);
    chk("R8 fwdData", fwdData, expFwd);
    // model update
    freeOk = (mCnt > 0) && mDn[mHead];
    rm = 0;
    for (int i = 0; i < D; i++) begin
      cmN[i] = mCm[i] || (commitEn && occ(i) && mSeq[i] < commitSeq);
      if (squashEn && occ(i) && mSeq[i] > squashSeq && !cmN[i]) rm++;
    end
    if (wrDoneEn && occ(wrDoneIdx) && mSt[wrDoneIdx]) mDn[wrDoneIdx] = 1;
    if (execEn && occ(execIdx)) begin
      mEx[execIdx] = 1; mAddr[execIdx] = execAddr; mSize[execIdx] = execSize; mData[execIdx] = execData;
    end
    for (int i = 0; i < D; i++) mCm[i] = cmN[i];
    if (expWr) begin mSt[mWb] = 1; mWb = (mWb + 1) % D; end
    if (freeOk) begin mHead = (mHead + 1) % D; mCnt--; end
    mTail = (mTail - rm + D) % D; mCnt -= rm;
    if (allocEn && !squashEn && !(storeCount >= D-1)) begin
      mSeq[mTail] = allocSeq; mEx[mTail] = 0; mCm[mTail] = 0; mSt[mTail] = 0; mDn[mTail] = 0;
      mTail = (mTail + 1) % D; mCnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    allocEn = 0; execEn = 0; commitEn = 0; squashEn = 0; wrDoneEn = 0; wrBlocked = 0;
  endtask

  task automatic randomInputs();
    int k;
    idle();
    allocEn = ($urandom % 3) == 0;
    if (allocEn) begin allocSeq = SW'(nextSeq); nextSeq += 1 + $urandom % 2; end
    if (mCnt > 0 && ($urandom % 2)) begin
      execEn = 1; execIdx = 3'((mHead + $urandom % mCnt) % D);
      execAddr = $urandom % 32; execSize = 2'($urandom); execData = {$urandom, $urandom};
    end
    if (mCnt > 0 && ($urandom % 4) == 0) begin
      commitEn = 1; commitSeq = SW'(mSeq[(mHead + $urandom % mCnt) % D] + 1);
    end
    if (($urandom % 40) == 0) begin
      squashEn = 1; squashSeq = (mCnt > 0) ? SW'(mSeq[(mHead + $urandom % mCnt) % D]) : SW'(nextSeq);
    end
    wrBlocked = ($urandom % 4) == 0;
    k = $urandom % D;
    for (int j = 0; j < D; j++) begin
      int s = (k + j) % D;
      if (!wrDoneEn && occ(s) && mSt[s] && !mDn[s] && ($urandom % 2)) begin
        wrDoneEn = 1; wrDoneIdx = 3'(s);
      end
    end
    ldSeq = SW'(nextSeq - int'($urandom % 6)); ldAddr = $urandom % 32; ldSize = 2'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1;
    chk("R1 count", storeCount, 0); chk("R1 pending", pendingWb, 0);
    chk("R1 full", sqFull, 0); chk("R1 wrValid", wrValid, 0);
    chk("R1 fwd", {fwdHit, fwdStall}, 0); chk("R1 allocIdx", allocIdx, 0);
    @(negedge clk);
    // R2 fill past capacity; last request must be ignored
    for (int i = 0; i < D + 1; i++) begin
      idle(); allocEn = 1; allocSeq = SW'(nextSeq); nextSeq += 2; cycle();
    end
    idle(); #1; chk("R2 full after fill", sqFull, 1); chk("R2 count at limit", storeCount, D-1);
    // directed forwarding: store at 0x10, 8 bytes
    idle(); execEn = 1; execIdx = 3'(mHead); execAddr = 32'h10; execSize = 2'd3;
    execData = 64'h8877665544332211; cycle();
    idle(); ldSeq = SW'(nextSeq); ldAddr = 32'h12; ldSize = 2'd1; cycle();   // R8 hit 0x4433
    idle(); ldSeq = SW'(nextSeq); ldAddr = 32'h0E; ldSize = 2'd2; cycle();   // R9 partial stall
    idle(); ldSeq = SW'(mSeq[mHead]); ldAddr = 32'h10; ldSize = 2'd0; cycle(); // R9 not older
    // R6 commit head, hold blocked for several cycles, then release
    idle(); commitEn = 1; commitSeq = SW'(mSeq[mHead] + 1); cycle();
    repeat (4) begin idle(); wrBlocked = 1; cycle(); end
    idle(); cycle();
    // R3 completion then release of the head
    idle(); wrDoneEn = 1; wrDoneIdx = 3'(mHead); cycle();
    idle(); cycle();
    // R10 squash the youngest half
    idle(); squashEn = 1; squashSeq = SW'(mSeq[(mHead + 2) % D]); cycle();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      randomInputs(); cycle();
    end
    // drain: commit everything, complete all writes
    for (int n = 0; n < 200; n++) begin
      idle(); commitEn = 1; commitSeq = SW'(nextSeq);
      for (int s = 0; s < D; s++) if (!wrDoneEn && occ(s) && mSt[s] && !mDn[s]) begin
        wrDoneEn = 1; wrDoneIdx = 3'(s);
      end
      for (int s = 0; s < D; s++) if (occ(s) && !mEx[s] && !execEn) begin
        execEn = 1; execIdx = 3'(s); execAddr = 32'h40; execSize = 2'd0; execData = 64'h5A;
      end
      cycle();
    end
    idle(); #1; chk("R3 drained count", storeCount, 0); chk("R7 drained pending", pendingWb, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule